// File: doc/BRIEF.md
# Synchronous Burst Static Memory

This block is a clocked, single-port word memory with a two-bit burst counter inside. A load cycle captures a full address, the chip selects and the transfer direction. Each advance cycle that follows steps the two lowest address bits while the upper bits stay fixed. A static pin chooses the step order: a linear sequence that wraps inside the aligned group of four words, or an interleaved sequence that XORs the start offset with a running count.

Writes can target single bytes of a word. A clock enable freezes every register. A static mode pin chooses the read path. In pipelined mode a read passes through an address stage and an output stage. In flow-through mode it passes through the address stage only, and write data moves one cycle earlier to match. An asynchronous output enable gates the drive flag, which stands in for the bus tristate control. A sleep input stops all accesses and keeps the stored words.

Top module: `burst_sram`

## Requirements
- R1: After reset, and until a read is issued, `rdDrive` is low.
- R2: An edge with `clkEnN` high changes no state. Read data and drive stay as they were, and a burst resumes where it stopped.
- R3: With `burstXor` = 0, burst beats address the start offset plus 1, 2, 3, modulo 4 in the two low address bits. Example: start 6 gives 6,7,4,5.
- R4: With `burstXor` = 1, burst beats address the start offset XOR 1, 2, 3. Example: start 5 gives 5,4,7,6.
- R5: A load (`advance` = 0) captures the address and the direction (`rdNotWr` 1 = read, 0 = write). On advance cycles `chipEn` and `rdNotWr` are ignored, and the burst keeps the direction of its load.
- R6: `byteWrEn[b]` set on a beat's address cycle lets byte lane b (bits 8b+7..8b) of that beat be written. Lanes with the bit clear keep their old contents.
- R7: With `pipeMode` = 1, read data and drive appear after the second enabled edge, counting the one that captures the address. Write data is taken on the edge after the address edge.
- R8: With `pipeMode` = 0, read data and drive appear after the address edge, and write data is taken on that same edge.
- R9: `rdDrive` is high only while `outEn` is high. Its effect is combinational, with no clock involved.
- R10: A load with any `chipEn` bit low performs no access. The drive drops after the same latency as read data, and the advances that follow neither read nor write.
- R11: While `sleep` is high, no access occurs, `rdDrive` is low, and the stored contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the control and output registers |
| clkEnN | input | 1 | Active-low clock enable |
| sleep | input | 1 | Low-power hold: no accesses |
| pipeMode | input | 1 | 1 = pipelined read path, 0 = flow-through (static) |
| burstXor | input | 1 | 1 = interleaved burst order, 0 = linear (static) |
| advance | input | 1 | 1 = step the burst counter, 0 = load a new address |
| addr | input | ADDR_W | Word address, used on load cycles |
| rdNotWr | input | 1 | 1 = read, 0 = write, used on load cycles |
| chipEn | input | CE_NUM | Chip selects, all must be high on a load |
| byteWrEn | input | BYTES | Per-lane write enables for the current beat |
| wrData | input | BYTES*BYTE_W | Write data |
| outEn | input | 1 | Asynchronous output enable |
| rdData | output | BYTES*BYTE_W | Read data |
| rdDrive | output | 1 | High when the data bus would be driven |

## Verification
The hardest situation to reach is a clock-enable stall in the middle of a pipelined read burst. There the held output stage and the held address stage must both resume without losing or repeating a beat. The stimulus reaches it by inserting a disabled edge directly after a load, so that the first word is still between the stages. The scoreboard then expects the beats on later edges, each shifted by one.

The second hard case is a partially selected load followed by advances that carry valid-looking write data. The stimulus checks it afterwards by reading the targeted word back through a normal burst.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  // Strobes passed from the command control to the storage datapath
  typedef struct packed {
    logic tick;     // enabled, awake clock edge
    logic we;       // write the selected lanes at this edge
    logic rdValid;  // address stage holds a live read
  } ctrl_strobe_t;
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2,
  parameter int CE_NUM = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              sleep,
  input  logic              pipeMode,
  input  logic              burstXor,
  input  logic              advance,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdNotWr,
  input  logic [CE_NUM-1:0] chipEn,
  input  logic [BYTES-1:0]  byteWrEn,
  output ctrl_strobe_t      stb,
  output logic [ADDR_W-1:0] wAddr,
  output logic [BYTES-1:0]  wBe,
  output logic [ADDR_W-1:0] rAddr
);
  localparam int HI_W = ADDR_W - 2;

  logic            tick;
  logic            selAll;
  logic            active;
  logic            dirRead;
  logic [HI_W-1:0] baseHi;
  logic [1:0]      startLo;
  logic [1:0]      cnt;
  logic [1:0]      nextCnt;
  logic [1:0]      burstLo;
  logic [ADDR_W-1:0] curAddr;
  logic            opValid;
  logic            opRead;

  logic              s1Valid;
  logic              s1Read;
  logic [ADDR_W-1:0] s1Addr;
  logic [BYTES-1:0]  s1Be;

  assign tick    = !clkEnN && !sleep;
  assign selAll  = &chipEn;
  assign nextCnt = cnt + 2'd1;
  assign burstLo = burstXor ? (startLo ^ nextCnt) : (startLo + nextCnt);
  assign curAddr = advance ? {baseHi, burstLo} : addr;
  assign opValid = advance ? active : selAll;
  assign opRead  = advance ? dirRead : rdNotWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      dirRead <= 1'b0;
      baseHi  <= '0;
      startLo <= '0;
      cnt     <= '0;
      s1Valid <= 1'b0;
      s1Read  <= 1'b0;
      s1Addr  <= '0;
      s1Be    <= '0;
    end else if (tick) begin
      if (!advance) begin
        active  <= selAll;
        dirRead <= rdNotWr;
        baseHi  <= addr[ADDR_W-1:2];
        startLo <= addr[1:0];
        cnt     <= '0;
      end else if (active) begin
        cnt <= nextCnt;
      end
      s1Valid <= opValid;
      s1Read  <= opRead;
      s1Addr  <= curAddr;
      s1Be    <= byteWrEn;
    end
  end

  always_comb begin
    stb.tick    = tick;
    stb.rdValid = s1Valid && s1Read;
    if (pipeMode) begin
      stb.we = tick && s1Valid && !s1Read;
      wAddr  = s1Addr;
      wBe    = s1Be;
    end else begin
      stb.we = tick && opValid && !opRead;
      wAddr  = curAddr;
      wBe    = byteWrEn;
    end
    rAddr = s1Addr;
  end
endmodule

// File: rtl/burst_sram_dp.sv
module burst_sram_dp
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    pipeMode,
  input  logic                    sleep,
  input  logic                    outEn,
  input  ctrl_strobe_t            stb,
  input  logic [ADDR_W-1:0]       wAddr,
  input  logic [BYTES-1:0]        wBe,
  input  logic [ADDR_W-1:0]       rAddr,
  input  logic [BYTES*BYTE_W-1:0] wrData,
  output logic [BYTES*BYTE_W-1:0] rdData,
  output logic                    rdDrive
);
  localparam int WORD_W = BYTES * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] dataQ;
  logic              driveQ;
  logic              driveSel;

  always_ff @(posedge clk) begin
    if (stb.we) begin
      for (int b = 0; b < BYTES; b++) begin
        if (wBe[b]) mem[wAddr][b*BYTE_W +: BYTE_W] <= wrData[b*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ  <= '0;
      driveQ <= 1'b0;
    end else if (stb.tick) begin
      dataQ  <= mem[rAddr];
      driveQ <= stb.rdValid;
    end
  end

  assign rdData   = pipeMode ? dataQ : mem[rAddr];
  assign driveSel = pipeMode ? driveQ : stb.rdValid;
  assign rdDrive  = driveSel && outEn && !sleep;
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 8,
  parameter int CE_NUM = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clkEnN,
  input  logic                    sleep,
  input  logic                    pipeMode,
  input  logic                    burstXor,
  input  logic                    advance,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    rdNotWr,
  input  logic [CE_NUM-1:0]       chipEn,
  input  logic [BYTES-1:0]        byteWrEn,
  input  logic [BYTES*BYTE_W-1:0] wrData,
  input  logic                    outEn,
  output logic [BYTES*BYTE_W-1:0] rdData,
  output logic                    rdDrive
);
  ctrl_strobe_t      stb;
  logic [ADDR_W-1:0] wAddr;
  logic [ADDR_W-1:0] rAddr;
  logic [BYTES-1:0]  wBe;

  burst_sram_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES), .CE_NUM(CE_NUM)) ctrl_i (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .sleep(sleep),
    .pipeMode(pipeMode), .burstXor(burstXor), .advance(advance),
    .addr(addr), .rdNotWr(rdNotWr), .chipEn(chipEn), .byteWrEn(byteWrEn),
    .stb(stb), .wAddr(wAddr), .wBe(wBe), .rAddr(rAddr)
  );

  burst_sram_dp #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) dp_i (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode), .sleep(sleep), .outEn(outEn),
    .stb(stb), .wAddr(wAddr), .wBe(wBe), .rAddr(rAddr), .wrData(wrData),
    .rdData(rdData), .rdDrive(rdDrive)
  );
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int WORD_W = 16,
  parameter int CE_NUM = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEnN,
  input logic              sleep,
  input logic              pipeMode,
  input logic              advance,
  input logic              rdNotWr,
  input logic [CE_NUM-1:0] chipEn,
  input logic              outEn,
  input logic [WORD_W-1:0] rdData,
  input logic              rdDrive
);
  logic enEdge;
  logic deselLoad;
  assign enEdge    = !clkEnN && !sleep;
  assign deselLoad = !advance && !(&chipEn) && enEdge;

  a_r9_oe_gates: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> !rdDrive);

  a_r11_sleep_quiet: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !rdDrive);

  a_r2_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    (clkEnN && pipeMode) |=> $stable(rdData));

  a_r10_desel_flow: assert property (@(posedge clk) disable iff (!rstN)
    (deselLoad && !pipeMode) |=> !rdDrive);

  a_r10_desel_pipe: assert property (@(posedge clk) disable iff (!rstN)
    (deselLoad && pipeMode) ##1 enEdge |=> !rdDrive);

  a_r8_flow_read: assert property (@(posedge clk) disable iff (!rstN)
    (!advance && (&chipEn) && rdNotWr && enEdge && !pipeMode)
      |=> (rdDrive || !outEn || sleep));
endmodule

bind burst_sram burst_sram_chk #(.WORD_W(BYTES*BYTE_W), .CE_NUM(CE_NUM)) chk_i (
  .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .sleep(sleep), .pipeMode(pipeMode),
  .advance(advance), .rdNotWr(rdNotWr), .chipEn(chipEn), .outEn(outEn),
  .rdData(rdData), .rdDrive(rdDrive)
);

// File: tb/burst_sram_tb_top.sv
module burst_sram_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkEnN = 1'b0;
  logic        sleep = 1'b0;
  logic        pipeMode = 1'b1;
  logic        burstXor = 1'b0;
  logic        advance = 1'b0;
  logic [5:0]  addr = '0;
  logic        rdNotWr = 1'b0;
  logic [2:0]  chipEn = '0;
  logic [1:0]  byteWrEn = '0;
  logic [15:0] wrData = '0;
  logic        outEn = 1'b1;
  logic [15:0] rdData;
  logic        rdDrive;

  int checks = 0;
  int failures = 0;
  int edgeCnt = 0;
  logic [15:0] model [64];

  typedef struct {
    int          due;
    logic        drv;
    logic [15:0] data;
    string       tag;
  } exp_t;
  exp_t q[$];

  burst_sram dut_i (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .sleep(sleep), .pipeMode(pipeMode),
    .burstXor(burstXor), .advance(advance), .addr(addr), .rdNotWr(rdNotWr),
    .chipEn(chipEn), .byteWrEn(byteWrEn), .wrData(wrData), .outEn(outEn),
    .rdData(rdData), .rdDrive(rdDrive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  // Monitor: compares scheduled expectations away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= edgeCnt) begin
      exp_t it;
      it = q.pop_front();
      checks++;
      if (it.due != edgeCnt) begin
        failures++;
        $display("FAIL %s: missed slot, actual edge %0d expected edge %0d", it.tag, edgeCnt, it.due);
      end else if (rdDrive !== it.drv || (it.drv && rdData !== it.data)) begin
        failures++;
        $display("FAIL %s: actual drive=%0b data=%h expected drive=%0b data=%h",
                 it.tag, rdDrive, rdData, it.drv, it.data);
      end
    end
  end

  task automatic drive(input logic adv, input logic [5:0] a, input logic rw,
                       input logic [2:0] ce, input logic [1:0] be, input logic [15:0] wd,
                       input logic ckn = 1'b0, input logic oe = 1'b1, input logic slp = 1'b0);
    @(posedge clk);
    #1;
    advance = adv; addr = a; rdNotWr = rw; chipEn = ce; byteWrEn = be;
    wrData = wd; clkEnN = ckn; outEn = oe; sleep = slp;
  endtask

  task automatic expect_rd(input int off, input logic [5:0] a, input string tag);
    exp_t it;
    it.due = edgeCnt + off; it.drv = 1'b1; it.data = model[a]; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic expect_off(input int off, input string tag);
    exp_t it;
    it.due = edgeCnt + off; it.drv = 1'b0; it.data = '0; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic mwrite(input logic [5:0] a, input logic [1:0] be, input logic [15:0] d);
    if (be[0]) model[a][7:0]  = d[7:0];
    if (be[1]) model[a][15:8] = d[15:8];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 6'd0, 1'b0, 3'b000, 2'b00, 16'h0);
  endtask

  task automatic finish_report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    failures++;
    $display("FAIL watchdog: actual run still busy, expected completion");
    finish_report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (rdDrive !== 1'b0) begin
      failures++;
      $display("FAIL R1: actual drive=%0b expected drive=0", rdDrive);
    end

    // Pipelined, linear: write burst from 4, data one cycle after address (R7)
    pipeMode = 1'b1; burstXor = 1'b0;
    idle(2);
    drive(1'b0, 6'd4, 1'b0, 3'b111, 2'b11, 16'h0);
    drive(1'b1, 6'd0, 1'b0, 3'b111, 2'b11, 16'h1104); mwrite(4, 2'b11, 16'h1104);
    // R5: read/write and chip enables ignored on an advance
    drive(1'b1, 6'd0, 1'b1, 3'b000, 2'b11, 16'h1105); mwrite(5, 2'b11, 16'h1105);
    drive(1'b1, 6'd0, 1'b0, 3'b111, 2'b11, 16'h1106); mwrite(6, 2'b11, 16'h1106);
    drive(1'b0, 6'd0, 1'b0, 3'b000, 2'b00, 16'h1107); mwrite(7, 2'b11, 16'h1107);

    // R3 linear read from 6: 6,7,4,5, pipelined latency R7
    drive(1'b0, 6'd6, 1'b1, 3'b111, 2'b00, 16'h0); expect_rd(2, 6, "R7 R3 beat0");
    drive(1'b1, 6'd0, 1'b0, 3'b000, 2'b00, 16'h0); expect_rd(2, 7, "R3 R5 beat1");
    drive(1'b1, 6'd0, 1'b0, 3'b000, 2'b00, 16'h0); expect_rd(2, 4, "R3 wrap beat2");
    drive(1'b1, 6'd0, 1'b0, 3'b000, 2'b00, 16'h0); expect_rd(2, 5, "R3 R5 beat3");
    drive(1'b0, 6'd0, 1'b0, 3'b000, 2'b00, 16'h0); expect_off(2, "R10 pipe drop");

    // R2: stall right after a pipelined load
    drive(1'b0, 6'd6, 1'b1, 3'b111, 2'b00, 16'h0); expect_off(2, "R2 stalled edge");
    drive(1'b1, 6'd0, 1'b0, 3'b000, 2'b00, 16'h0, 1'b1); expect_rd(2, 6, "R2 resume beat0");
    drive(1'b1, 6'd0, 1'b0, 3'b000, 2'b00, 16'h0); expect_rd(2, 7, "R2 resume beat1");
    drive(1'b0, 6'd0, 1'b0, 3'b000, 2'b00, 16'h0); expect_off(2, "R2 end");
    idle(3);

    // R4 interleaved write from 5 (5,4,7,6) with per-beat lane enables R6
    burstXor = 1'b1;
    idle(1);
    drive(1'b0, 6'd5, 1'b0, 3'b111, 2'b01, 16'h0);
    drive(1'b1, 6'd0, 1'b0, 3'b111, 2'b10, 16'h5A55); mwrite(5, 2'b01, 16'h5A55);
    drive(1'b1, 6'd0, 1'b0, 3'b111, 2'b11, 16'h5A54); mwrite(4, 2'b10, 16'h5A54);
    drive(1'b1, 6'd0, 1'b0, 3'b111, 2'b00, 16'h5A57); mwrite(7, 2'b11, 16'h5A57);
    drive(1'b0, 6'd0, 1'b0, 3'b000, 2'b00, 16'h5A56); mwrite(6, 2'b00, 16'h5A56);

    drive(1'b0, 6'd5, 1'b1, 3'b111, 2'b00, 16'h0); expect_rd(2, 5, "R4 R6 lane0 only");
    drive(1'b1, 6'd0, 1'b0, 3'b000, 2'b00, 16'h0); expect_rd(2, 4, "R4 R6 lane1 only");
    drive(1'b1, 6'd0, 1'b0, 3'b000, 2'b00, 16'h0); expect_rd(2, 7, "R4 R6 both lanes");
    drive(1'b1, 6'd0, 1'b0, 3'b000, 2'b00, 16'h0); expect_rd(2, 6, "R4 R6 no lane");
    drive(1'b0, 6'd0, 1'b0, 3'b000, 2'b00, 16'h0); expect_off(2, "R10 pipe drop");
    idle(3);

    // Flow-through, linear: write data with its address R8
    pipeMode = 1'b0; burstXor = 1'b0;
    idle(2);
    drive(1'b0, 6'd8, 1'b0, 3'b111, 2'b11, 16'h3308); mwrite(8,  2'b11, 16'h3308);
    drive(1'b1, 6'd0, 1'b0, 3'b111, 2'b11, 16'h3309); mwrite(9,  2'b11, 16'h3309);
    drive(1'b1, 6'd0, 1'b0, 3'b111, 2'b11, 16'h330A); mwrite(10, 2'b11, 16'h330A);
    drive(1'b1, 6'd0, 1'b0, 3'b111, 2'b11, 16'h330B); mwrite(11, 2'b11, 16'h330B);
    drive(1'b0, 6'd0, 1'b0, 3'b000, 2'b00, 16'h0);

    drive(1'b0, 6'd10, 1'b1, 3'b111, 2'b00, 16'h0); expect_rd(1, 10, "R8 beat0");
    drive(1'b1, 6'd0, 1'b0, 3'b111, 2'b00, 16'h0); expect_rd(1, 11, "R8 R3 beat1");
    drive(1'b1, 6'd0, 1'b0, 3'b111, 2'b00, 16'h0); expect_rd(1, 8, "R8 R3 wrap");
    drive(1'b0, 6'd0, 1'b0, 3'b000, 2'b00, 16'h0); expect_off(1, "R10 flow drop");

    // R10: partially selected write load plus advances must not write
    drive(1'b0, 6'd8, 1'b0, 3'b011, 2'b11, 16'hDEAD);
    drive(1'b1, 6'd0, 1'b0, 3'b111, 2'b11, 16'hBEEF); expect_off(1, "R10 no read");
    drive(1'b0, 6'd0, 1'b0, 3'b000, 2'b00, 16'h0);
    drive(1'b0, 6'd8, 1'b1, 3'b111, 2'b00, 16'h0); expect_rd(1, 8, "R10 word kept");
    drive(1'b0, 6'd9, 1'b1, 3'b101, 2'b00, 16'h0); expect_off(1, "R10 desel read");
    drive(1'b1, 6'd0, 1'b1, 3'b111, 2'b00, 16'h0); expect_off(1, "R10 advance ignored");
    drive(1'b0, 6'd0, 1'b0, 3'b000, 2'b00, 16'h0);
    idle(2);

    // R9: output enable acts in the same cycle
    drive(1'b0, 6'd9, 1'b1, 3'b111, 2'b00, 16'h0);
    drive(1'b1, 6'd0, 1'b0, 3'b000, 2'b00, 16'h0, 1'b0, 1'b0); expect_off(0, "R9 oe low");
    drive(1'b0, 6'd0, 1'b0, 3'b000, 2'b00, 16'h0, 1'b0, 1'b1); expect_rd(0, 10, "R9 oe high");
    idle(2);

    // R11: sleep blocks drive and writes, contents kept
    drive(1'b0, 6'd10, 1'b1, 3'b111, 2'b00, 16'h0);
    drive(1'b1, 6'd0, 1'b0, 3'b000, 2'b00, 16'h0, 1'b0, 1'b1, 1'b1); expect_off(0, "R11 no drive");
    drive(1'b0, 6'd9, 1'b0, 3'b111, 2'b11, 16'hFFFF, 1'b0, 1'b1, 1'b1);
    drive(1'b0, 6'd0, 1'b0, 3'b000, 2'b00, 16'h0);
    drive(1'b0, 6'd9, 1'b1, 3'b111, 2'b00, 16'h0); expect_rd(1, 9, "R11 contents kept");
    drive(1'b0, 6'd0, 1'b0, 3'b000, 2'b00, 16'h0); expect_off(1, "R10 flow drop");
    idle(4);

    finish_report();
  end
endmodule